// File: doc/BRIEF.md
# EEPROM Page Buffer and Word Address Counter

This unit sits between a serial protocol front end and a 256-byte storage array. It owns the internal word address counter, gathers the data bytes of a page write into an eight-slot buffer, and, on a commit strobe, copies the buffered bytes into their page over a timed busy interval. It also returns read data while moving the counter forward. The front end turns its bus events into single-cycle strobes: load an address, accept a data byte, advance a read, commit, or abort.

Writes and reads move the same counter in different ways. A write byte steps only the low three bits, so the address stays on its 8-byte page and comes back to the start of that page. A read steps the full address, so it crosses page boundaries and goes back to address 0 after address 255. The counter keeps its value between transactions. A current-address read that follows a write therefore starts at the in-page location after the last byte written.

Top module: `eeprom_page_unit`

## Requirements
- R1: After synchronous reset the counter is 0, every array byte reads 0x00, `busy` is low and `rd_data` is 0x00.
- R2: When idle, a `load_addr` strobe sets the counter to `addr_in`.
- R3: When idle, each `wr_byte` strobe stores `wr_data` in buffer slot `counter[2:0]` and increments only `counter[2:0]`, leaving `counter[7:3]` unchanged, so offset 7 is followed by offset 0 of the same page.
- R4: If more than eight bytes arrive in one page write, a later byte at an offset replaces the earlier buffered byte there, and only the last one is committed.
- R5: A commit writes only the buffer slots filled since the last commit or abort. Other bytes of the page keep their old contents.
- R6: When idle, a `rd_adv` strobe puts the array byte at the counter on `rd_data` one cycle later and increments the full counter, wrapping from 255 to 0.
- R7: The counter keeps its value between transactions. A read that follows a page write of k bytes starting at address a begins at `{a[7:3], (a[2:0]+k) mod 8}`.
- R8: A commit with at least one filled slot raises `busy` on the next cycle and holds it for exactly `BUSY_CYCLES` cycles. The array is updated by the time `busy` falls. A commit with no filled slot does not raise `busy`.
- R9: While `busy` is high, every strobe is ignored. The counter, the buffer and `rd_data` do not change.
- R10: An `abort` strobe empties the buffer without writing the array and without raising `busy`. The counter keeps its value.
- R11: When several strobes arrive together, only one acts, by priority: abort, commit, wr_byte, load_addr, rd_adv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_addr | input | 1 | Load the word address counter from `addr_in` |
| addr_in | input | 8 | Word address to load |
| wr_byte | input | 1 | Accept one page-write data byte |
| wr_data | input | 8 | Data byte for `wr_byte` |
| rd_adv | input | 1 | Read the byte at the counter and advance it |
| commit | input | 1 | Start the timed write of the buffered bytes |
| abort | input | 1 | Discard the buffered bytes |
| busy | output | 1 | Timed write cycle in progress; strobes ignored |
| rd_data | output | 8 | Byte returned by the last accepted `rd_adv` |

## Verification
The embedded assertions check four things on every cycle:
- a write strobe leaves the page bits of the counter untouched;
- the counter holds still while `busy` is high;
- `busy` rises only after an accepted commit and never exceeds its cycle budget;
- an abort or a finished commit leaves no slot marked filled.

Several behaviours show only in the bench's scenarios, read back through `rd_data`:
- wrap within the page and the last-write-wins overwrite;
- the untouched neighbour bytes;
- the counter position after a write;
- read wrap from 255 to 0;
- strobe priority.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ABORT,
        OP_COMMIT,
        OP_WRITE,
        OP_LOAD,
        OP_READ
    } op_e;

    typedef struct packed {
        logic  filled;
        byte_t data;
    } slot_t;

    // One operation per cycle; nothing is accepted during the timed write.
    function automatic op_e pick_op(input logic busy, input logic ab,
                                    input logic cm, input logic wr,
                                    input logic ld, input logic rd);
        op_e op;
        op = OP_NONE;
        if (!busy) begin
            if (ab)      op = OP_ABORT;
            else if (cm) op = OP_COMMIT;
            else if (wr) op = OP_WRITE;
            else if (ld) op = OP_LOAD;
            else if (rd) op = OP_READ;
        end
        return op;
    endfunction

endpackage

// File: rtl/eepg_addr_ctr.sv
module eepg_addr_ctr
    import eepg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  off_next;
    logic [ADDR_W-1:0] addr_next;

    always_comb begin
        off_next = addr[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1};
        unique case (op)
            OP_LOAD:  addr_next = addr_in;
            OP_WRITE: addr_next = {addr[ADDR_W-1:OFF_W], off_next};
            OP_READ:  addr_next = addr + {{(ADDR_W-1){1'b0}}, 1'b1};
            default:  addr_next = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else     addr <= addr_next;
    end

    logic [PAGE_W-1:0] page_unused;
    assign page_unused = addr[ADDR_W-1:OFF_W];

endmodule

// File: rtl/eepg_page_buf.sv
module eepg_page_buf
    import eepg_pkg::*;
#(
    parameter int OFF_W  = 3,
    parameter int PAGE_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        flush,
    input  logic [PAGE_W-1:0]           page_in,
    input  logic [OFF_W-1:0]            off_in,
    input  byte_t                       data_in,
    output logic [PAGE_W-1:0]           page,
    output slot_t [(1<<OFF_W)-1:0]      slots,
    output logic                        any_filled
);
    localparam int NSLOT = 1 << OFF_W;

    logic [NSLOT-1:0] filled_vec;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[i] <= '0;
            end else if (wr_en && off_in == OFF_W'(i)) begin
                slots[i].filled <= 1'b1;
                slots[i].data   <= data_in;
            end
        end
        assign filled_vec[i] = slots[i].filled;
    end

    always_ff @(posedge clk) begin
        if (rst)        page <= '0;
        else if (wr_en) page <= page_in;
    end

    assign any_filled = |filled_vec;

    // Flush must leave no slot marked (R5, R10)
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (filled_vec == '0));

endmodule

// File: rtl/eepg_wr_timer.sv
module eepg_wr_timer #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(BUSY_CYCLES);
    localparam logic [CW-1:0] ONE_V  = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (start)       remain <= LOAD_V;
        else if (remain != 0) remain <= remain - ONE_V;
    end

    assign busy = (remain != '0);
    assign done = (remain == ONE_V);

    assert_budget_R8: assert property (@(posedge clk) disable iff (rst)
        remain <= LOAD_V);

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/eepg_array.sv
module eepg_array
    import eepg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wen,
    input  logic [ADDR_W-OFF_W-1:0]            wpage,
    input  slot_t [(1<<OFF_W)-1:0]             wslots,
    input  logic                               ren,
    input  logic [ADDR_W-1:0]                  raddr,
    output byte_t                              rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NSLOT = 1 << OFF_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (wen) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (wslots[i].filled) mem[{wpage, OFF_W'(i)}] <= wslots[i].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      rdata <= '0;
        else if (ren) rdata <= mem[raddr];
    end

endmodule

// File: rtl/eeprom_page_unit.sv
module eeprom_page_unit
    import eepg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int OFF_W       = 3,
    parameter int BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int NSLOT  = 1 << OFF_W;

    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [PAGE_W-1:0] buf_page;
    slot_t [NSLOT-1:0] slots;
    logic              any_filled;
    logic              wr_done;
    logic              start_wr;

    assign op       = pick_op(busy, abort, commit, wr_byte, load_addr, rd_adv);
    assign start_wr = (op == OP_COMMIT) && any_filled;

    eepg_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .addr_in (addr_in),
        .addr    (addr)
    );

    eepg_page_buf #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (op == OP_WRITE),
        .flush      (wr_done || op == OP_ABORT),
        .page_in    (addr[ADDR_W-1:OFF_W]),
        .off_in     (addr[OFF_W-1:0]),
        .data_in    (wr_data),
        .page       (buf_page),
        .slots      (slots),
        .any_filled (any_filled)
    );

    eepg_wr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (start_wr),
        .busy  (busy),
        .done  (wr_done)
    );

    eepg_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .wen    (wr_done),
        .wpage  (buf_page),
        .wslots (slots),
        .ren    (op == OP_READ),
        .raddr  (addr),
        .rdata  (rd_data)
    );

    // Writes keep the page row of the counter
    assert_page_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> (addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W])));

    // Nothing moves the counter during the timed write
    assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr));

    // busy only starts from an accepted commit with pending data
    assert_busy_origin_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(op == OP_COMMIT && any_filled));

    // Buffer content must not change while the write is in flight
    assert_buf_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_done) |=> $stable(slots));

endmodule

// File: tb/eeprom_page_unit_tb.sv
module eeprom_page_unit_tb;
    localparam int BUSY = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_addr = 0, wr_byte = 0, rd_adv = 0, commit = 0, abort = 0;
    logic [7:0] addr_in = 0, wr_data = 0;
    logic       busy;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [7:0] m_mem [256];
    logic [7:0] m_cnt;
    logic [7:0] m_dat [8];
    bit         m_val [8];
    logic [4:0] m_page;

    eeprom_page_unit #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst(rst), .load_addr(load_addr), .addr_in(addr_in),
        .wr_byte(wr_byte), .wr_data(wr_data), .rd_adv(rd_adv),
        .commit(commit), .abort(abort), .busy(busy), .rd_data(rd_data));

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input bit ld, input logic [7:0] a, input bit wr,
                          input logic [7:0] d, input bit rd, input bit cm, input bit ab);
        @(negedge clk);
        load_addr = ld; addr_in = a; wr_byte = wr; wr_data = d;
        rd_adv = rd; commit = cm; abort = ab;
        @(negedge clk);
        load_addr = 0; wr_byte = 0; rd_adv = 0; commit = 0; abort = 0;
    endtask

    function automatic bit m_any();
        for (int i = 0; i < 8; i++) if (m_val[i]) return 1;
        return 0;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_dat[i] = 0; end
    endfunction

    task automatic t_load(input logic [7:0] a);
        strobe(1, a, 0, 0, 0, 0, 0);
        m_cnt = a;
    endtask

    task automatic t_wr(input logic [7:0] d);
        strobe(0, 0, 1, d, 0, 0, 0);
        m_dat[m_cnt[2:0]] = d;
        m_val[m_cnt[2:0]] = 1;
        m_page = m_cnt[7:3];
        m_cnt = {m_cnt[7:3], m_cnt[2:0] + 3'd1};
    endtask

    task automatic t_rd(input string req);
        strobe(0, 0, 0, 0, 1, 0, 0);
        chk(rd_data == m_mem[m_cnt], req, rd_data, m_mem[m_cnt]);
        m_cnt = m_cnt + 8'd1;
    endtask

    task automatic t_commit(input string req);
        int n;
        bit exp_busy;
        exp_busy = m_any();
        strobe(0, 0, 0, 0, 0, 1, 0);
        n = 0;
        while (busy && n < 10 * BUSY) begin n++; @(negedge clk); end
        chk(n == (exp_busy ? BUSY : 0), req, n, exp_busy ? BUSY : 0);
        for (int i = 0; i < 8; i++)
            if (m_val[i]) m_mem[{m_page, 3'(i)}] = m_dat[i];
        m_clear();
    endtask

    task automatic t_abort();
        strobe(0, 0, 0, 0, 0, 0, 1);
        chk(busy == 0, "R10", busy, 0);
        m_clear();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd4242));
        for (int a = 0; a < 256; a++) m_mem[a] = 0;
        m_cnt = 0; m_page = 0; m_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        chk(busy == 0, "R1", busy, 0);
        chk(rd_data == 0, "R1", rd_data, 0);
        t_rd("R1");
        t_rd("R1");

        // R2, R6: preload last page then read across 255 -> 0
        t_load(8'd248);
        for (int i = 0; i < 8; i++) t_wr(8'hA0 + 8'(i));
        t_commit("R8");
        t_load(8'd254);
        for (int i = 0; i < 4; i++) t_rd("R6");
        chk(m_cnt == 8'd2, "R6", m_cnt, 2);

        // R3, R4, R7: 11 bytes from 0x13 wrap in page 2
        t_load(8'h13);
        for (int i = 0; i < 11; i++) t_wr(8'h30 + 8'(i));
        chk(m_cnt == 8'h16, "R7", m_cnt, 8'h16);
        t_commit("R8");
        t_rd("R7");
        t_load(8'h10);
        for (int i = 0; i < 8; i++) t_rd("R4");

        // R5: partial write keeps neighbours
        t_load(8'h40);
        for (int i = 0; i < 8; i++) t_wr(8'h55);
        t_commit("R8");
        t_load(8'h45);
        t_wr(8'hC1); t_wr(8'hC2);
        t_commit("R8");
        t_load(8'h40);
        for (int i = 0; i < 8; i++) t_rd("R5");

        // R10: abort discards, counter kept, then empty commit gives no busy
        t_load(8'h60);
        t_wr(8'h11); t_wr(8'h22); t_wr(8'h33);
        t_abort();
        t_rd("R10");
        t_commit("R8");
        t_load(8'h60);
        for (int i = 0; i < 3; i++) t_rd("R10");

        // R9: strobes during busy are ignored
        t_load(8'h80);
        t_wr(8'h9A);
        strobe(0, 0, 0, 0, 0, 1, 0);
        chk(busy == 1, "R8", busy, 1);
        keep = rd_data;
        strobe(1, 8'h07, 1, 8'hEE, 1, 0, 0);
        chk(rd_data == keep, "R9", rd_data, keep);
        while (busy) @(negedge clk);
        m_mem[8'h80] = 8'h9A; m_clear();
        t_commit("R9");
        t_rd("R9");

        // R11: load and read together, load wins
        strobe(1, 8'h80, 0, 0, 1, 0, 0);
        m_cnt = 8'h80;
        chk(rd_data == keep, "R11", rd_data, keep);
        t_rd("R11");
        // commit with write together: commit wins, byte dropped
        strobe(0, 0, 1, 8'h77, 0, 1, 0);
        chk(busy == 0, "R11", busy, 0);
        t_commit("R11");

        // Constrained random mix
        for (int it = 0; it < 250; it++) begin
            int kind;
            kind = $urandom_range(0, 3);
            if (kind < 2) begin
                int nb;
                t_load(8'($urandom_range(0, 255)));
                nb = $urandom_range(1, 12);
                for (int b = 0; b < nb; b++) t_wr(8'($urandom_range(0, 255)));
                if ($urandom_range(0, 7) == 0) t_abort();
                else t_commit("R8");
            end else begin
                int nr;
                if (kind == 2) t_load(8'($urandom_range(0, 255)));
                nr = $urandom_range(1, 10);
                for (int r = 0; r < nr; r++) t_rd("R6");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule